// File: doc/BRIEF.md
# Slot-Based Priority Interrupt Controller

This block collects a set of interrupt sources into groups of eight. It keeps a pending state for each source and picks one winner among the sources that are both pending and enabled. It reports the winner through a vector register and raises a single request line towards the processor. Software reaches every control through a simple synchronous 32-bit register bus. The bus has a write strobe, a read strobe, a word index and a read data register that loads on the edge where the read strobe is sampled.

Each source has a sense mode. An edge source latches a rising edge until software clears it. A level source follows its input. A force bit can hold a source pending from software. The arbitration order of a programmable group comes from eight numbered slots, and each slot names the 3-bit in-group code of one source. Pairs of groups can be interleaved slot by slot instead of being ordered one group after the other. Groups without a slot register rank after every programmable group, ordered by source number. A field in the configuration register can name one source that wins whenever it is pending and enabled.

Source n (counting from 0) belongs to group n/8 and has in-group code n%8. It is reported as vector n+1.

Top module: `slotpic_top`

## Requirements
- R1: After reset the mask, force, sense, configuration and pending state are all zero, the vector reads 0 and irq_out is low. Every slot register reads back with slot k holding code k, where slot k (k<4) sits at bits 20+(3-k)*3 and slot k (k>=4) sits at bits 4+(7-k)*3.
- R2: Source n uses bit 31-n of the pending (index 0), mask (index 1) and force (index 2) words. A source is recorded as pending whatever its mask bit says, but only a source with mask bit 1 can win the vector or raise irq_out.
- R3: Writing 1 to pending bit 31-n clears a latched edge of source n, and writing 0 leaves it set. A level source keeps following its input after such a write.
- R4: Sense word (index 3) bit 15-i set makes input i edge-sensitive, so a one-cycle pulse stays pending. With the bit clear, the input is level-sensitive and the pending bit drops with the input.
- R5: In grouped order (the reset default), a lower slot number wins within a group, every source of group 0 beats every source of group 1, and the group without a slot register (group 2) ranks after both.
- R6: Slot register g sits at index 6+g, and the fields follow the positions of R1. If a code sits in several slots, the lowest of those slots counts.
- R7: Configuration (index 4) bit 0 set interleaves groups 0 and 1 as slot0 of group0, slot0 of group1, slot1 of group0, and so on.
- R8: Configuration bits 30:24 hold a vector number. When the source it names is pending and enabled, that source wins over any slot order. Otherwise the field has no effect.
- R9: The vector word (index 5) returns winner n+1 in bits 6:0, and 0 when no source is pending and enabled. It follows the current pending and mask state.
- R10: irq_out is high exactly one cycle after some source is pending and enabled, and drops one cycle after none is.
- R11: A set force bit keeps its source pending until the bit is cleared.
- R12: A source whose code sits in no slot, and every source of a group without a slot register, ranks after all slotted sources. Such sources are ordered by ascending source number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_GROUPS*8 | Interrupt source inputs, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | $clog2(6+NUM_PRIO_GROUPS) | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, loaded on the edge that samples rd_en |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
A wrong slot search or wrong rank arithmetic changes which number the vector word returns as soon as two enabled sources are pending together. The directed pairs are chosen so that each slot position and each group order gives a different answer. A stale edge latch shows up in the next pending or vector read, either as a bit that will not clear or as one that a write of zero removes. The request line has its own one-cycle window, so an extra or missing register stage on it is caught on the first edge after a source is enabled.

// File: rtl/slotpic_pkg.sv
// Shared constants and helpers for the slot-based interrupt controller.
// Assumes 32-bit register words and eight slots of 3-bit codes per group.
package slotpic_pkg;
    localparam int WORD_W  = 32;
    localparam int SLOTS   = 8;
    localparam int CODE_W  = 3;
    localparam int VEC_W   = 7;

    // register word indices
    localparam int RI_PEND   = 0;
    localparam int RI_MASK   = 1;
    localparam int RI_FORCE  = 2;
    localparam int RI_SENSE  = 3;
    localparam int RI_CONFIG = 4;
    localparam int RI_VECTOR = 5;
    localparam int RI_PRIO   = 6;

    // lowest bit of a slot field inside a slot register word
    function automatic int slot_lsb(input int slot);
        return (slot < 4) ? (20 + (3 - slot) * 3) : (4 + (7 - slot) * 3);
    endfunction
endpackage

// File: rtl/slotpic_pending.sv
// Per-source pending state: samples the inputs, latches rising edges for
// edge-mode sources and ORs in software force bits.
// Assumes irq_in is already synchronous to clk.
module slotpic_pending #(
    parameter int NUM_SRC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic [NUM_SRC-1:0] force_src,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] in_q;
    logic [NUM_SRC-1:0] edge_q;

    // sample the raw inputs once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= irq_in;
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        // latch rising edges, drop on W1C, set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n || !edge_mode[n])
                edge_q[n] <= 1'b0;
            else if (irq_in[n] && !in_q[n])
                edge_q[n] <= 1'b1;
            else if (clr[n])
                edge_q[n] <= 1'b0;
        end
        // pick latched or sampled level, plus software force
        assign pend[n] = (edge_mode[n] ? edge_q[n] : in_q[n]) | force_src[n];
    end
endmodule

// File: rtl/slotpic_rank.sv
// Turns slot registers into a numeric rank per source (lower wins).
// Grouped: pair*16 + half*8 + slot. Spread: pair*16 + slot*2 + half.
// Unslotted sources and groups without a slot register rank after all
// slotted sources, in source-number order.
module slotpic_rank #(
    parameter int NUM_SRC         = 24,
    parameter int NUM_PRIO_GROUPS = 2,
    parameter int NUM_PAIRS       = 1,
    parameter int RANK_W          = 6
) (
    input  logic [NUM_PRIO_GROUPS-1:0][slotpic_pkg::SLOTS-1:0][slotpic_pkg::CODE_W-1:0] slot_code,
    input  logic [NUM_PAIRS-1:0]                  spread,
    output logic [NUM_SRC-1:0][RANK_W-1:0]        rank
);
    import slotpic_pkg::*;
    localparam int BASE = NUM_PRIO_GROUPS * SLOTS;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_rank
        localparam int G = s / SLOTS;
        localparam int C = s % SLOTS;
        if (G < NUM_PRIO_GROUPS) begin : g_prog
            localparam int P = G / 2;
            localparam int H = G % 2;
            logic hit;
            int   slot;
            int   r;
            // find the lowest slot naming this code and form the rank
            always_comb begin
                hit  = 1'b0;
                slot = 0;
                for (int k = SLOTS - 1; k >= 0; k--) begin
                    if (slot_code[G][k] == CODE_W'(C)) begin
                        hit  = 1'b1;
                        slot = k;
                    end
                end
                if (!hit)
                    r = BASE + s;
                else if (spread[P])
                    r = P * 16 + slot * 2 + H;
                else
                    r = P * 16 + H * 8 + slot;
                rank[s] = RANK_W'(r);
            end
        end else begin : g_fixed
            assign rank[s] = RANK_W'(BASE + s);
        end
    end
endmodule

// File: rtl/slotpic_arbiter.sv
// Selects the winning source among pending-and-enabled ones: an override
// source wins if active, else the lowest rank, ties to the lower number.
// Output is vector = source index + 1, or 0 when nothing is active.
module slotpic_arbiter #(
    parameter int NUM_SRC = 24,
    parameter int RANK_W  = 6
) (
    input  logic [NUM_SRC-1:0]              act,
    input  logic [NUM_SRC-1:0][RANK_W-1:0]  rank,
    input  logic [slotpic_pkg::VEC_W-1:0]   ovr_num,
    output logic [slotpic_pkg::VEC_W-1:0]   vector
);
    import slotpic_pkg::*;
    logic              found;
    logic [RANK_W-1:0] best_rank;
    int                best_idx;
    logic              ovr_hit;

    // linear minimum search in ascending source order
    always_comb begin
        found     = 1'b0;
        best_rank = '1;
        best_idx  = 0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (act[s] && (!found || rank[s] < best_rank)) begin
                found     = 1'b1;
                best_rank = rank[s];
                best_idx  = s;
            end
        end
    end

    // override applies only when its source is active
    assign ovr_hit = (ovr_num != '0) && (ovr_num <= VEC_W'(NUM_SRC)) &&
                     (|(act & (NUM_SRC'(1) << (ovr_num - VEC_W'(1)))));

    // final vector selection
    always_comb begin
        if (ovr_hit)    vector = ovr_num;
        else if (found) vector = VEC_W'(best_idx + 1);
        else            vector = '0;
    end
endmodule

// File: rtl/slotpic_top.sv
// Slot-based priority interrupt controller: register file, pending logic,
// rank calculation and arbitration. Registers are MSB-first per source.
// Assumes NUM_GROUPS*8 <= 32 and NUM_EXT <= 16.
module slotpic_top #(
    parameter int NUM_GROUPS      = 3,
    parameter int NUM_PRIO_GROUPS = 2,
    parameter int NUM_EXT         = 16,
    localparam int NUM_SRC        = NUM_GROUPS * 8,
    localparam int ADDR_W         = $clog2(6 + NUM_PRIO_GROUPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               irq_out
);
    import slotpic_pkg::*;
    localparam int NUM_PAIRS = (NUM_PRIO_GROUPS + 1) / 2;
    localparam int RANK_W    = $clog2(NUM_PRIO_GROUPS * SLOTS + NUM_SRC);

    logic [NUM_SRC-1:0] mask_q, force_q, pend_w, act_w, clr_w, edge_src, wsrc;
    logic [NUM_EXT-1:0] sense_q;
    logic [VEC_W-1:0]   ovr_q, vec_w;
    logic [NUM_PAIRS-1:0] spread_q;
    logic [NUM_PRIO_GROUPS-1:0][SLOTS-1:0][CODE_W-1:0] slot_q;
    logic [NUM_SRC-1:0][RANK_W-1:0] rank_w;
    logic [31:0] rd_word, rdata_q;
    logic        irq_q;

    // map a write word to sources, MSB-first
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
        assign wsrc[n]  = wdata[31-n];
        assign clr_w[n] = wr_en && (addr == ADDR_W'(RI_PEND)) && wdata[31-n];
        if (n < NUM_EXT) begin : g_ext
            assign edge_src[n] = sense_q[n];
        end else begin : g_int
            assign edge_src[n] = 1'b0;
        end
    end

    assign act_w = pend_w & mask_q;

    // register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            force_q  <= '0;
            sense_q  <= '0;
            ovr_q    <= '0;
            spread_q <= '0;
            for (int g = 0; g < NUM_PRIO_GROUPS; g++)
                for (int k = 0; k < SLOTS; k++)
                    slot_q[g][k] <= CODE_W'(k);
        end else if (wr_en) begin
            if (addr == ADDR_W'(RI_MASK))  mask_q  <= wsrc;
            if (addr == ADDR_W'(RI_FORCE)) force_q <= wsrc;
            if (addr == ADDR_W'(RI_SENSE))
                for (int i = 0; i < NUM_EXT; i++) sense_q[i] <= wdata[15-i];
            if (addr == ADDR_W'(RI_CONFIG)) begin
                ovr_q    <= wdata[30:24];
                spread_q <= wdata[NUM_PAIRS-1:0];
            end
            for (int g = 0; g < NUM_PRIO_GROUPS; g++)
                if (addr == ADDR_W'(RI_PRIO + g))
                    for (int k = 0; k < SLOTS; k++)
                        slot_q[g][k] <= wdata[slot_lsb(k) +: CODE_W];
        end
    end

    // read data selection
    always_comb begin
        rd_word = '0;
        if (addr == ADDR_W'(RI_PEND))
            for (int n = 0; n < NUM_SRC; n++) rd_word[31-n] = pend_w[n];
        if (addr == ADDR_W'(RI_MASK))
            for (int n = 0; n < NUM_SRC; n++) rd_word[31-n] = mask_q[n];
        if (addr == ADDR_W'(RI_FORCE))
            for (int n = 0; n < NUM_SRC; n++) rd_word[31-n] = force_q[n];
        if (addr == ADDR_W'(RI_SENSE))
            for (int i = 0; i < NUM_EXT; i++) rd_word[15-i] = sense_q[i];
        if (addr == ADDR_W'(RI_CONFIG)) begin
            rd_word[30:24]          = ovr_q;
            rd_word[NUM_PAIRS-1:0]  = spread_q;
        end
        if (addr == ADDR_W'(RI_VECTOR))
            rd_word[VEC_W-1:0] = vec_w;
        for (int g = 0; g < NUM_PRIO_GROUPS; g++)
            if (addr == ADDR_W'(RI_PRIO + g))
                for (int k = 0; k < SLOTS; k++)
                    rd_word[slot_lsb(k) +: CODE_W] = slot_q[g][k];
    end

    // registered read data and request line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (rd_en) rdata_q <= rd_word;
            irq_q <= |act_w;
        end
    end

    assign rdata   = rdata_q;
    assign irq_out = irq_q;

    slotpic_pending #(.NUM_SRC(NUM_SRC)) pend_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_mode(edge_src),
        .force_src(force_q), .clr(clr_w), .pend(pend_w)
    );

    slotpic_rank #(.NUM_SRC(NUM_SRC), .NUM_PRIO_GROUPS(NUM_PRIO_GROUPS),
                   .NUM_PAIRS(NUM_PAIRS), .RANK_W(RANK_W)) rank_i (
        .slot_code(slot_q), .spread(spread_q), .rank(rank_w)
    );

    slotpic_arbiter #(.NUM_SRC(NUM_SRC), .RANK_W(RANK_W)) arb_i (
        .act(act_w), .rank(rank_w), .ovr_num(ovr_q), .vector(vec_w)
    );
endmodule

// File: rtl/slotpic_checker.sv
// Property checker for slotpic_top, attached by bind.
// Relates the request line, the arbiter output and the active set.
module slotpic_checker #(
    parameter int NUM_SRC = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_out,
    input logic [6:0]         vector,
    input logic [NUM_SRC-1:0] act,
    input logic [6:0]         ovr_num
);
    logic vec_hit, ovr_hit;
    assign vec_hit = |(act & (NUM_SRC'(1) << (vector - 7'd1)));
    assign ovr_hit = (ovr_num != 7'd0) && (ovr_num <= 7'(NUM_SRC)) &&
                     (|(act & (NUM_SRC'(1) << (ovr_num - 7'd1))));

    a_r9_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (vector == 7'd0));

    a_r9_vector_is_active: assert property (@(posedge clk) disable iff (!rst_n)
        (vector != 7'd0) |-> (vector <= 7'(NUM_SRC) && vec_hit));

    a_r8_override_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_hit |-> (vector == ovr_num));

    a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(vector != 7'd0));

    a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(act == '0));
endmodule

bind slotpic_top slotpic_checker #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .vector(vec_w),
    .act(act_w), .ovr_num(ovr_q)
);

// File: tb/slotpic_tb.sv
// Directed bench for slotpic_top: one task per scenario.
module slotpic_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_in = '0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq_out;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slotpic_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_out(irq_out)
    );

    localparam logic [2:0] A_PEND = 0, A_MASK = 1, A_FORCE = 2, A_SENSE = 3,
                           A_CFG = 4, A_VEC = 5, A_PRIO0 = 6, A_PRIO1 = 7;

    function automatic logic [31:0] sbit(input int n);
        return 32'h1 << (31 - n);
    endfunction

    // build a slot word from codes, slot k at codes[3k+:3]
    function automatic logic [31:0] slot_word(input logic [23:0] codes);
        logic [31:0] w = '0;
        for (int k = 0; k < 8; k++) begin
            int lsb = (k < 4) ? 20 + (3 - k) * 3 : 4 + (7 - k) * 3;
            w[lsb +: 3] = codes[3*k +: 3];
        end
        return w;
    endfunction

    function automatic logic [23:0] default_codes();
        logic [23:0] c;
        for (int k = 0; k < 8; k++) c[3*k +: 3] = 3'(k);
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic clean();
        irq_in = '0;
        bus_write(A_MASK, 0);
        bus_write(A_FORCE, 0);
        bus_write(A_SENSE, 0);
        bus_write(A_CFG, 0);
        bus_write(A_PRIO0, slot_word(default_codes()));
        bus_write(A_PRIO1, slot_word(default_codes()));
        bus_write(A_PEND, 32'hFFFF_FFFF);
        tick();
    endtask

    task automatic expect_vec(input string req, input int v);
        logic [31:0] d;
        tick();
        bus_read(A_VEC, d);
        check(req, d, 32'(v));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_PEND, d);  check("R1 pend", d, 0);
        bus_read(A_MASK, d);  check("R1 mask", d, 0);
        bus_read(A_CFG, d);   check("R1 config", d, 0);
        bus_read(A_VEC, d);   check("R1 vector", d, 0);
        bus_read(A_PRIO0, d); check("R1 slot reg0", d, slot_word(default_codes()));
        bus_read(A_PRIO1, d); check("R1 slot reg1", d, slot_word(default_codes()));
        check("R1 irq_out", 32'(irq_out), 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        clean();
        irq_in[3] = 1'b1;
        tick();
        bus_read(A_PEND, d); check("R2 pend while masked", d, sbit(3));
        bus_read(A_VEC, d);  check("R2 vector while masked", d, 0);
        check("R2 irq while masked", 32'(irq_out), 0);
        bus_write(A_MASK, sbit(3));
        bus_read(A_VEC, d);  check("R2 vector enabled", d, 4);
        check("R2 irq enabled", 32'(irq_out), 1);
    endtask

    task automatic t_sense_w1c();
        logic [31:0] d;
        clean();
        bus_write(A_SENSE, 32'h1 << (15 - 5));
        bus_write(A_MASK, sbit(5) | sbit(6));
        @(negedge clk); irq_in[5] = 1'b1; irq_in[6] = 1'b1;
        @(negedge clk); irq_in[5] = 1'b0; irq_in[6] = 1'b0;
        tick();
        bus_read(A_PEND, d); check("R4 edge latched, level dropped", d, sbit(5));
        bus_read(A_VEC, d);  check("R4 vector edge source", d, 6);
        bus_write(A_PEND, 0);
        bus_read(A_PEND, d); check("R3 write zero no effect", d, sbit(5));
        bus_write(A_PEND, sbit(5));
        bus_read(A_PEND, d); check("R3 W1C clears edge", d, 0);
        irq_in[6] = 1'b1;
        bus_write(A_PEND, sbit(6));
        tick();
        bus_read(A_PEND, d); check("R3 level follows input", d, sbit(6));
    endtask

    task automatic t_grouped();
        logic [23:0] c;
        clean();
        bus_write(A_MASK, 32'hFFFF_FF00);
        irq_in = '0; irq_in[2] = 1; irq_in[5] = 1;
        expect_vec("R5 default slot order", 3);
        c = default_codes(); c[2:0] = 3'd5;
        bus_write(A_PRIO0, slot_word(c));
        expect_vec("R6 lowest slot of repeated code", 6);
        c = '0; c[3*4 +: 3] = 3'd3; c[3*6 +: 3] = 3'd6;
        bus_write(A_PRIO0, slot_word(c));
        irq_in = '0; irq_in[3] = 1; irq_in[6] = 1;
        expect_vec("R6 slot4 beats slot6", 4);
        c = '0; c[3*4 +: 3] = 3'd6; c[3*6 +: 3] = 3'd3;
        bus_write(A_PRIO0, slot_word(c));
        expect_vec("R6 swapped slots", 7);
        bus_write(A_PRIO0, slot_word(default_codes()));
        irq_in = '0; irq_in[7] = 1; irq_in[9] = 1;
        expect_vec("R5 group0 before group1", 8);
        irq_in = '0; irq_in[15] = 1; irq_in[16] = 1;
        expect_vec("R5 slotted group before fixed group", 16);
        irq_in = '0; irq_in[16] = 1; irq_in[17] = 1;
        expect_vec("R12 fixed group by number", 17);
    endtask

    task automatic t_unslotted();
        clean();
        bus_write(A_MASK, 32'hFFFF_FF00);
        bus_write(A_PRIO1, 0);
        irq_in = '0; irq_in[9] = 1; irq_in[20] = 1;
        expect_vec("R12 unslotted before higher number fixed", 10);
        irq_in[8] = 1;
        expect_vec("R12 slotted beats unslotted", 9);
    endtask

    task automatic t_spread();
        logic [31:0] d;
        clean();
        bus_write(A_MASK, 32'hFFFF_FF00);
        irq_in = '0; irq_in[1] = 1; irq_in[8] = 1;
        expect_vec("R7 grouped reference", 2);
        bus_write(A_CFG, 32'h1);
        expect_vec("R7 interleaved order", 9);
        bus_read(A_CFG, d); check("R7 config readback", d, 32'h1);
    endtask

    task automatic t_override();
        clean();
        bus_write(A_MASK, 32'hFFFF_FF00 & ~sbit(21));
        irq_in = '0; irq_in[1] = 1; irq_in[20] = 1;
        bus_write(A_CFG, 32'(21) << 24);
        expect_vec("R8 override wins", 21);
        bus_write(A_CFG, 32'(22) << 24);
        expect_vec("R8 override inactive", 2);
        irq_in[21] = 1;
        expect_vec("R8 override masked", 2);
    endtask

    task automatic t_force();
        logic [31:0] d;
        clean();
        bus_write(A_MASK, sbit(12));
        bus_write(A_FORCE, sbit(12));
        tick();
        bus_read(A_PEND, d); check("R11 forced pending", d, sbit(12));
        bus_read(A_VEC, d);  check("R11 forced vector", d, 13);
        check("R11 forced irq", 32'(irq_out), 1);
        bus_write(A_FORCE, 0);
        expect_vec("R11 force released", 0);
    endtask

    task automatic t_irq_timing();
        clean();
        bus_write(A_MASK, sbit(4));
        @(negedge clk); irq_in[4] = 1'b1;
        @(posedge clk); #1; check("R10 not yet high", 32'(irq_out), 0);
        @(posedge clk); #1; check("R10 high after one cycle", 32'(irq_out), 1);
        @(negedge clk); irq_in[4] = 1'b0;
        @(posedge clk); #1; check("R10 still high", 32'(irq_out), 1);
        @(posedge clk); #1; check("R10 low after one cycle", 32'(irq_out), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_sense_w1c();
        t_grouped();
        t_unslotted();
        t_spread();
        t_override();
        t_force();
        t_irq_timing();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule